// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges thirteen interrupt sources onto the single interrupt request line of a processor core. Each source input is edge-sensitive. A rising edge records a pending event for that source, and the event stays recorded until the core acknowledges that source. Every source has its own enable bit and its own 4-bit priority level, which software can set. When at least one enabled source is pending, the controller raises its request. At the same time it presents a vector address that belongs to the winning source.

The winner is the enabled pending source with the largest level. When levels are equal, the lowest source index wins. Once the request is raised, the winner and its vector are frozen until the core pulses the acknowledge. After the acknowledge, the winner's pending event is cleared, the request drops for one cycle, and arbitration starts again over whatever is still pending. How the core nests interrupts is outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` equals VEC_BASE (0x0100 by default), and no source is pending.
- R2: A 0-to-1 transition of `src_in[i]` between two clock samples marks source i pending. A level held high does not mark it again after it has been acknowledged.
- R3: Among enabled pending sources, the one with the largest level wins. The level of source i is `prio_cfg[4*i+3:4*i]`, read as unsigned.
- R4: When two or more winning candidates share the same largest level, the one with the lowest index wins.
- R5: While `irq_req` is 1, `irq_vec` equals VEC_BASE plus the index of the winning source.
- R6: A source whose `src_en` bit is 0 still becomes pending on an edge but does not take part in arbitration. Setting its enable later makes it request.
- R7: `irq_req` rises on the clock edge that follows the edge at which an enabled source became pending. It therefore never shows in the same cycle as the source edge.
- R8: While `irq_req` is 1 and `irq_ack` is 0, `irq_req` stays 1 and `irq_vec` stays unchanged, even if a higher-level source becomes pending or the levels change.
- R9: `irq_ack` sampled high while `irq_req` is 1 does two things on that edge. It clears the winner's pending event and drops `irq_req` for the next cycle. Other pending sources keep their events and are arbitrated next.
- R10: `irq_ack` sampled high while `irq_req` is 0 has no effect on any pending event.
- R11: If a new rising edge of the winning source is sampled on the same edge as its acknowledge, the source stays pending and requests again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 13 | Source event inputs, rising-edge sensitive |
| src_en | input | 13 | Per-source arbitration enable |
| prio_cfg | input | 52 | Packed 4-bit priority level per source, source i at bits 4i+3..4i |
| irq_ack | input | 1 | Acknowledge from the core for the presented vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winning source |

## Verification
The pending flag has two functions that can act on the same clock edge: it is set by a new source edge and cleared by the acknowledge of that same source. The bench provokes this by raising the winning source's input and `irq_ack` together, after the same falling clock edge. The set must win, so the bench expects `irq_req` to drop for one cycle and then return with the same vector. A second overlap is a higher-level event arriving while a request is held. That case is judged by checking that the vector stays unchanged until the acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Vector address for a source index relative to a base address.
  function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                           input logic [31:0] idx);
    return base + idx;
  endfunction

  // True when level a strictly outranks level b (larger value wins).
  function automatic logic lvl_beats(input logic [31:0] a,
                                     input logic [31:0] b);
    return a > b;
  endfunction

  // One-hot decode of an index into a 32-bit mask.
  function automatic logic [31:0] idx_onehot(input logic [31:0] idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] clr_ev,
  output logic [NUM_SRC-1:0] rise_ev,
  output logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] src_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign rise_ev[i] = src_in[i] & ~src_d[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_d[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        src_d[i] <= src_in[i];
        // a fresh edge wins over a clear on the same edge
        pend[i]  <= rise_ev[i] | (pend[i] & ~clr_ev[i]);
      end
    end
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int LVL_W   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       cand,
  input  logic [NUM_SRC*LVL_W-1:0] prio_cfg,
  output logic                     grant_vld,
  output logic [IDX_W-1:0]         grant_idx
);

  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    best_lvl  = '0;
    // ascending scan, strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i]) begin
        if (!grant_vld ||
            lvl_beats(32'(prio_cfg[i*LVL_W +: LVL_W]), 32'(best_lvl))) begin
          grant_vld = 1'b1;
          grant_idx = IDX_W'(i);
          best_lvl  = prio_cfg[i*LVL_W +: LVL_W];
        end
      end
    end
  end

endmodule

// File: rtl/irq_hold.sv
module irq_hold
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant_vld,
  input  logic [IDX_W-1:0]   grant_idx,
  input  logic               ack,
  output logic               req,
  output logic [IDX_W-1:0]   win_idx,
  output logic               take,
  output logic               launch,
  output logic [NUM_SRC-1:0] clr_ev
);

  logic [31:0] clr_wide;

  assign take     = req & ack;
  assign launch   = ~req & grant_vld;
  assign clr_wide = idx_onehot(32'(win_idx));
  assign clr_ev   = take ? clr_wide[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req     <= 1'b0;
      win_idx <= '0;
    end else if (take) begin
      req     <= 1'b0;
    end else if (launch) begin
      req     <= 1'b1;
      win_idx <= grant_idx;
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_SRC  = 13,
  parameter int          LVL_W    = 4,
  parameter int          VEC_W    = 16,
  parameter logic [31:0] VEC_BASE = 32'h0000_0100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_in,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC*LVL_W-1:0] prio_cfg,
  input  logic                     irq_ack,
  output logic                     irq_req,
  output logic [VEC_W-1:0]         irq_vec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] rise_ev;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr_ev;
  logic [NUM_SRC-1:0] cand;
  logic               grant_vld;
  logic [IDX_W-1:0]   grant_idx;
  logic [IDX_W-1:0]   win_idx;
  logic               take;
  logic               launch;
  logic [31:0]        vec_wide;

  assign cand = pend & src_en;

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .clr_ev  (clr_ev),
    .rise_ev (rise_ev),
    .pend    (pend)
  );

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .cand      (cand),
    .prio_cfg  (prio_cfg),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  irq_hold #(.NUM_SRC(NUM_SRC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx),
    .ack       (irq_ack),
    .req       (irq_req),
    .win_idx   (win_idx),
    .take      (take),
    .launch    (launch),
    .clr_ev    (clr_ev)
  );

  assign vec_wide = vec_addr(VEC_BASE, 32'(win_idx));
  assign irq_vec  = vec_wide[VEC_W-1:0];

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NUM_SRC = 13,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] src_en,
  input logic [NUM_SRC-1:0] rise_ev,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] clr_ev,
  input logic [IDX_W-1:0]   win_idx,
  input logic               take,
  input logic               irq_ack,
  input logic               irq_req,
  input logic [15:0]        irq_vec
);

  // R8: held request keeps its vector until acknowledged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  // R9: acknowledge of a live request drops it on the next cycle
  p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req);

  // R9: at most one pending event is cleared per edge
  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_ev));

  // R5: a presented winner is always still pending
  p_win_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[win_idx]);

  // R11: acknowledge clears the winner unless a new edge collides
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rise_ev[win_idx] |=> !pend[$past(win_idx)]);

  // R10: an acknowledge with no live request clears nothing
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !irq_req |-> clr_ev == '0);

  // R7: no request without an enabled pending source
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && ((pend & src_en) == '0) |=> !irq_req);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    // R2: a sampled rising edge leaves the source pending
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_in[i]) |=> pend[i]);
  end

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_in  (src_in),
  .src_en  (src_en),
  .rise_ev (rise_ev),
  .pend    (pend),
  .clr_ev  (clr_ev),
  .win_idx (win_idx),
  .take    (take),
  .irq_ack (irq_ack),
  .irq_req (irq_req),
  .irq_vec (irq_vec)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;

  localparam int N    = 13;
  localparam int LW   = 4;
  localparam int BASE = 'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic [N-1:0]  src_en = '0;
  logic [N*LW-1:0] prio_cfg = '0;
  logic          irq_ack = 1'b0;
  logic          irq_req;
  logic [15:0]   irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
    .prio_cfg(prio_cfg), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d, expected end before it", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp_req, input int exp_idx);
    n_chk++;
    if (irq_req !== exp_req) begin
      n_bad++;
      $display("FAIL %s: irq_req actual %b expected %b", tag, irq_req, exp_req);
    end else if (exp_req && irq_vec !== 16'(BASE + exp_idx)) begin
      n_bad++;
      $display("FAIL %s: irq_vec actual %h expected %h", tag, irq_vec, 16'(BASE + exp_idx));
    end
  endtask

  task automatic set_lvl(input int i, input int v);
    prio_cfg[i*LW +: LW] = LW'(v);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_in = src_in | m;
    step(1);
    src_in = src_in & ~m;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    n_chk++;
    if (irq_req !== 1'b0 || irq_vec !== 16'(BASE)) begin
      n_bad++;
      $display("FAIL R1: req/vec actual %b/%h expected 0/%h", irq_req, irq_vec, 16'(BASE));
    end
    src_en = '1;
    step(2);
    check("R1 nothing pending after reset", 1'b0, 0);
  endtask

  task automatic t_single();
    pulse(N'(1) << 5);
    check("R7 no request in the edge cycle", 1'b0, 0);
    step(1);
    check("R5 R7 single source 5", 1'b1, 5);
    ack_once();
    check("R9 request drops after ack", 1'b0, 0);
    step(2);
    check("R9 source 5 cleared", 1'b0, 0);
  endtask

  task automatic t_level_held();
    src_in[3] = 1'b1;
    step(2);
    check("R2 held level first request", 1'b1, 3);
    ack_once();
    step(3);
    check("R2 held level does not retrigger", 1'b0, 0);
    src_in[3] = 1'b0;
    step(1);
  endtask

  task automatic t_priority();
    set_lvl(2, 3); set_lvl(7, 9); set_lvl(11, 9);
    pulse((N'(1) << 2) | (N'(1) << 7) | (N'(1) << 11));
    step(1);
    check("R3 R4 level 9 tie lower index 7", 1'b1, 7);
    ack_once();
    check("R9 gap after ack", 1'b0, 0);
    step(1);
    check("R9 R4 next source 11 kept pending", 1'b1, 11);
    ack_once();
    step(1);
    check("R3 lowest level source 2 last", 1'b1, 2);
    ack_once();
    step(1);
    check("R9 all served", 1'b0, 0);
    prio_cfg = '0;
  endtask

  task automatic t_disabled();
    src_en[4] = 1'b0;
    set_lvl(4, 15);
    pulse((N'(1) << 4) | (N'(1) << 1));
    step(1);
    check("R6 disabled source 4 skipped", 1'b1, 1);
    ack_once();
    step(2);
    check("R6 disabled source does not request", 1'b0, 0);
    src_en[4] = 1'b1;
    step(1);
    check("R6 enabled source 4 requests", 1'b1, 4);
    ack_once();
    prio_cfg = '0;
    step(1);
  endtask

  task automatic t_stable();
    set_lvl(0, 1);
    pulse(N'(1));
    step(1);
    check("R8 held source 0", 1'b1, 0);
    set_lvl(12, 15);
    pulse(N'(1) << 12);
    set_lvl(0, 0);
    step(3);
    check("R8 vector unchanged by higher arrival", 1'b1, 0);
    ack_once();
    step(1);
    check("R8 R3 source 12 after ack", 1'b1, 12);
    ack_once();
    prio_cfg = '0;
    step(1);
  endtask

  task automatic t_ack_idle();
    src_en[6] = 1'b0;
    pulse(N'(1) << 6);
    step(1);
    check("R10 idle before ack", 1'b0, 0);
    ack_once();
    ack_once();
    src_en[6] = 1'b1;
    step(1);
    check("R10 idle ack left source 6 pending", 1'b1, 6);
    ack_once();
    step(2);
    check("R10 source 6 served", 1'b0, 0);
  endtask

  task automatic t_collide();
    pulse(N'(1) << 9);
    step(1);
    check("R11 request source 9", 1'b1, 9);
    irq_ack = 1'b1;
    src_in[9] = 1'b1;
    step(1);
    irq_ack = 1'b0;
    src_in[9] = 1'b0;
    check("R11 drop after colliding ack", 1'b0, 0);
    step(1);
    check("R11 source 9 requests again", 1'b1, 9);
    ack_once();
    step(2);
    check("R11 then cleared", 1'b0, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_level_held();
    t_priority();
    t_disabled();
    t_stable();
    t_ack_idle();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule